// File: doc/BRIEF.md
# I2C Ten-Bit Slave Address Matcher

This block decides, on the slave side of an I2C bus, whether a transfer that uses ten-bit addressing is meant for this device. It does not touch the bus pins. A bit-level front end passes it bus events: START or repeated START, STOP, each completed eight-bit byte with a one-cycle valid strobe, and a level that is high for the ninth (acknowledge) clock of that byte. From these events and a programmed ten-bit own address, the matcher requests an acknowledge for each byte it accepts and reports whether the device is currently addressed, and in which direction.

Recognition takes two steps. The first byte after a START carries the fixed five-bit header `11110`, then own-address bits 9 and 8, then the direction bit. Several devices that share those two upper bits may accept this byte together. The second byte carries address bits 7 to 0. Only the device whose low eight bits match accepts it, and that device becomes uniquely addressed. It stays addressed until a STOP, or until a repeated START is followed by a header that is not its own. After a repeated START, a matching header alone restores the device, and the header's direction bit selects write or read.

Top module: `i2c10_addr_match`

## Requirements
- R1: After reset, `ack_req_o`, `addressed_o` and `write_o` are all 0.
- R2: A first byte equal to {`11110`, own[9:8], 0} after a START is acknowledged. `addressed_o` stays 0 after that byte.
- R3: A first byte whose header or bits 9:8 differ from {`11110`, own[9:8]} is not acknowledged. No later byte is acknowledged until the next START, even one equal to own[7:0].
- R4: A first byte with direction bit 1, received while the device was not addressed before the START, is not acknowledged. The matcher then ignores bytes until the next START.
- R5: A second byte equal to own[7:0] after an accepted first byte is acknowledged. `addressed_o` and `write_o` then both read 1.
- R6: A second byte that differs from own[7:0] is not acknowledged. `addressed_o` stays 0, and the following bytes are not acknowledged.
- R7: While the device is addressed with `write_o` = 1, every data byte is acknowledged.
- R8: A STOP clears `addressed_o`, `write_o` and any pending acknowledge request by the next cycle.
- R9: While addressed, a repeated START keeps `addressed_o` at 1. If the repeated START is followed by the device's own first byte with direction 0, that byte is acknowledged and the next byte is taken as data and acknowledged.
- R10: While addressed, a repeated START followed by a first byte that is not the device's own header ends the addressed state. That byte is not acknowledged.
- R11: While addressed, a repeated START followed by the own header with direction bit 1 is acknowledged. `addressed_o` stays 1, `write_o` goes to 0, and the following data bytes are not acknowledged.
- R12: An acknowledge request rises in the cycle after the byte's valid strobe. It stays high for the whole ninth-clock window and falls in the cycle after `ack_slot_i` goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle pulse on START or repeated START |
| stop_i | input | 1 | One-cycle pulse on STOP |
| byte_valid_i | input | 1 | One-cycle pulse when `byte_i` holds a complete received byte |
| byte_i | input | 8 | Received byte, most significant bit first on the bus |
| ack_slot_i | input | 1 | High during the ninth clock of the current byte |
| own_addr_i | input | 10 | Programmed ten-bit own address |
| ack_req_o | output | 1 | Request to drive the acknowledge for the current byte |
| addressed_o | output | 1 | The device is uniquely addressed |
| write_o | output | 1 | Addressed, and the master is transmitting |

## Verification
The bench applies a full header, low-byte and data sequence, then variants that change one part at a time. The variants are a wrong header bit, a set direction bit on a fresh transfer, and a wrong low byte. Together they show which of the two compare stages rejected the transfer and that the rejection holds until the next START. Repeated-START sequences with the same header, a different header and a read header show that the held addressed state is either kept, dropped, or switched in direction. Every byte also checks the acknowledge window, so any shift in the timing of the request shows up on each transfer.

// File: rtl/i2c10m_pkg.sv
package i2c10m_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    M_IDLE = 3'd0,
    M_HDR  = 3'd1,
    M_LOW  = 3'd2,
    M_DATA = 3'd3,
    M_SKIP = 3'd4
  } match_st_e;

  // Header check: top seven bits against {prefix, own upper bits}
  function automatic logic hdr_equal(input logic [BYTE_W-1:0] b,
                                     input logic [BYTE_W-2:0] expect_top);
    return b[BYTE_W-1:1] == expect_top;
  endfunction

  function automatic logic low_equal(input logic [BYTE_W-1:0] b,
                                     input logic [BYTE_W-1:0] own_low);
    return b == own_low;
  endfunction
endpackage

// File: rtl/i2c10m_cmp.sv
module i2c10m_cmp
  import i2c10m_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int PFX_W  = 5,
  parameter logic [PFX_W-1:0] PREFIX = 5'b11110
) (
  input  logic [BYTE_W-1:0] byte_i,
  input  logic [ADDR_W-1:0] own_addr_i,
  output logic              hdr_hit_o,
  output logic              low_hit_o,
  output logic              dir_rd_o
);
  localparam int HI_W = ADDR_W - BYTE_W;

  logic [BYTE_W-2:0] top_expect;
  assign top_expect = {PREFIX, own_addr_i[ADDR_W-1 -: HI_W]};

  always_comb begin
    hdr_hit_o = hdr_equal(byte_i, top_expect);
    low_hit_o = low_equal(byte_i, own_addr_i[BYTE_W-1:0]);
    dir_rd_o  = byte_i[0];
  end

  initial begin
    assert (PFX_W + HI_W == BYTE_W - 1)
      else $error("header width mismatch");
  end
endmodule

// File: rtl/i2c10m_ack.sv
module i2c10m_ack (
  input  logic clk,
  input  logic rst_n,
  input  logic kill_i,
  input  logic set_i,
  input  logic slot_i,
  output logic ack_o
);
  logic slot_q;
  logic slot_fall;
  assign slot_fall = slot_q && !slot_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= 1'b0;
      ack_o  <= 1'b0;
    end else begin
      slot_q <= slot_i;
      if (kill_i)         ack_o <= 1'b0;
      else if (set_i)     ack_o <= 1'b1;
      else if (slot_fall) ack_o <= 1'b0;
    end
  end

  // R12
  ack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_fall && !set_i) |=> !ack_o);

  // R12
  ack_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_o) |-> $past(set_i));
endmodule

// File: rtl/i2c10m_fsm.sv
module i2c10m_fsm
  import i2c10m_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start_i,
  input  logic      stop_i,
  input  logic      byte_valid_i,
  input  logic      hdr_hit_i,
  input  logic      low_hit_i,
  input  logic      dir_rd_i,
  output logic      ack_set_o,
  output logic      ack_kill_o,
  output logic      addressed_o,
  output logic      write_o,
  output match_st_e state_o
);
  match_st_e st_q, st_d;
  logic held_q, held_d;
  logic addr_q, addr_d;
  logic wr_q, wr_d;

  always_comb begin
    st_d = st_q;
    held_d = held_q;
    addr_d = addr_q;
    wr_d = wr_q;
    ack_set_o = 1'b0;
    ack_kill_o = 1'b0;
    if (stop_i) begin
      st_d = M_IDLE;
      held_d = 1'b0;
      addr_d = 1'b0;
      wr_d = 1'b0;
      ack_kill_o = 1'b1;
    end else if (start_i) begin
      st_d = M_HDR;
      held_d = addr_q;
      ack_kill_o = 1'b1;
    end else if (byte_valid_i) begin
      unique case (st_q)
        M_HDR: begin
          held_d = 1'b0;
          if (hdr_hit_i && !dir_rd_i) begin
            ack_set_o = 1'b1;
            st_d = held_q ? M_DATA : M_LOW;
            wr_d = held_q;
          end else if (hdr_hit_i && held_q) begin
            ack_set_o = 1'b1;
            st_d = M_DATA;
            wr_d = 1'b0;
          end else begin
            ack_kill_o = 1'b1;
            st_d = M_SKIP;
            addr_d = 1'b0;
            wr_d = 1'b0;
          end
        end
        M_LOW: begin
          if (low_hit_i) begin
            ack_set_o = 1'b1;
            st_d = M_DATA;
            addr_d = 1'b1;
            wr_d = 1'b1;
          end else begin
            ack_kill_o = 1'b1;
            st_d = M_SKIP;
          end
        end
        M_DATA: begin
          if (wr_q) ack_set_o = 1'b1;
          else      ack_kill_o = 1'b1;
        end
        default: ack_kill_o = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= M_IDLE;
      held_q <= 1'b0;
      addr_q <= 1'b0;
      wr_q <= 1'b0;
    end else begin
      st_q <= st_d;
      held_q <= held_d;
      addr_q <= addr_d;
      wr_q <= wr_d;
    end
  end

  assign addressed_o = addr_q;
  assign write_o = wr_q;
  assign state_o = st_q;

  // R8
  stop_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_i |=> (!addressed_o && !write_o));

  // R5
  addr_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(addressed_o) |-> ($past(byte_valid_i) && $past(st_q) == M_LOW));

  // R11
  write_implies_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    write_o |-> addressed_o);

  // R3
  skip_no_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == M_SKIP) |-> !ack_set_o);
endmodule

// File: rtl/i2c10_addr_match.sv
module i2c10_addr_match
  import i2c10m_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter logic [4:0] PREFIX = 5'b11110
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              byte_valid_i,
  input  logic [7:0]        byte_i,
  input  logic              ack_slot_i,
  input  logic [ADDR_W-1:0] own_addr_i,
  output logic              ack_req_o,
  output logic              addressed_o,
  output logic              write_o
);
  localparam int PFX_W = BYTE_W - 1 - (ADDR_W - BYTE_W);

  logic hdr_hit, low_hit, dir_rd;
  logic ack_set, ack_kill;
  match_st_e st;

  i2c10m_cmp #(.ADDR_W(ADDR_W), .PFX_W(PFX_W), .PREFIX(PREFIX)) cmp_i (
    .byte_i(byte_i), .own_addr_i(own_addr_i),
    .hdr_hit_o(hdr_hit), .low_hit_o(low_hit), .dir_rd_o(dir_rd)
  );

  i2c10m_fsm fsm_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
    .byte_valid_i(byte_valid_i), .hdr_hit_i(hdr_hit), .low_hit_i(low_hit),
    .dir_rd_i(dir_rd), .ack_set_o(ack_set), .ack_kill_o(ack_kill),
    .addressed_o(addressed_o), .write_o(write_o), .state_o(st)
  );

  i2c10m_ack ack_i (
    .clk(clk), .rst_n(rst_n), .kill_i(ack_kill), .set_i(ack_set),
    .slot_i(ack_slot_i), .ack_o(ack_req_o)
  );

  // R8
  stop_ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_i |=> !ack_req_o);

  // R10
  hdr_miss_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_valid_i && !start_i && !stop_i && st == M_HDR && !hdr_hit) |=>
      (!addressed_o && !ack_req_o));
endmodule

// File: tb/i2c10_addr_match_tb_top.sv
module i2c10_addr_match_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0, stop_i = 1'b0, byte_valid_i = 1'b0, ack_slot_i = 1'b0;
  logic [7:0] byte_i = 8'h00;
  logic [9:0] own_addr_i = 10'h2B5;
  logic ack_req_o, addressed_o, write_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  i2c10_addr_match dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
    .byte_valid_i(byte_valid_i), .byte_i(byte_i), .ack_slot_i(ack_slot_i),
    .own_addr_i(own_addr_i), .ack_req_o(ack_req_o),
    .addressed_o(addressed_o), .write_o(write_o)
  );

  // Expected header bytes built from the requirement encoding
  function automatic logic [7:0] hdr(input logic [1:0] hi, input logic rd);
    return {5'b11110, hi, rd};
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
  endtask

  task automatic pulse_stop();
    @(negedge clk) stop_i = 1'b1;
    @(negedge clk) stop_i = 1'b0;
    check(!addressed_o && !write_o && !ack_req_o, "R8",
          {addressed_o, write_o, ack_req_o}, 0);
  endtask

  // Sends one byte, runs its ninth-clock window and checks R12 timing
  task automatic send_byte(input logic [7:0] b, input bit exp_ack, input string req);
    logic seen;
    @(negedge clk) begin byte_valid_i = 1'b1; byte_i = b; end
    @(negedge clk) byte_valid_i = 1'b0;
    check(ack_req_o == exp_ack, "R12 rise", ack_req_o, exp_ack);
    @(negedge clk) ack_slot_i = 1'b1;
    @(negedge clk) seen = ack_req_o;
    check(seen == exp_ack, req, seen, exp_ack);
    @(negedge clk) ack_slot_i = 1'b0;
    @(negedge clk);
    check(ack_req_o == 1'b0, "R12 fall", ack_req_o, 0);
  endtask

  task automatic expect_state(input bit a, input bit w, input string req);
    check(addressed_o == a && write_o == w, req, {addressed_o, write_o}, {a, w});
  endtask

  task automatic t_reset();
    check(!ack_req_o && !addressed_o && !write_o, "R1",
          {ack_req_o, addressed_o, write_o}, 0);
  endtask

  task automatic t_basic_write();
    pulse_start();
    send_byte(hdr(2'b10, 1'b0), 1'b1, "R2");
    expect_state(1'b0, 1'b0, "R2 not yet addressed");
    send_byte(8'hB5, 1'b1, "R5");
    expect_state(1'b1, 1'b1, "R5");
    send_byte(8'h3C, 1'b1, "R7");
    send_byte(8'h00, 1'b1, "R7");
    pulse_stop();
  endtask

  task automatic t_hdr_miss();
    pulse_start();
    send_byte(hdr(2'b01, 1'b0), 1'b0, "R3 upper bits");
    send_byte(8'hB5, 1'b0, "R3 ignored");
    expect_state(1'b0, 1'b0, "R3");
    pulse_start();
    send_byte(8'h74, 1'b0, "R3 prefix");
    pulse_stop();
  endtask

  task automatic t_read_fresh();
    pulse_start();
    send_byte(hdr(2'b10, 1'b1), 1'b0, "R4");
    send_byte(8'hB5, 1'b0, "R4 ignored");
    expect_state(1'b0, 1'b0, "R4");
    pulse_stop();
  endtask

  task automatic t_low_miss();
    pulse_start();
    send_byte(hdr(2'b10, 1'b0), 1'b1, "R2");
    send_byte(8'hB4, 1'b0, "R6");
    expect_state(1'b0, 1'b0, "R6");
    send_byte(8'hB5, 1'b0, "R6 later byte");
    pulse_stop();
  endtask

  task automatic addr_write();
    pulse_start();
    send_byte(hdr(2'b10, 1'b0), 1'b1, "R2");
    send_byte(8'hB5, 1'b1, "R5");
  endtask

  task automatic t_rs_same();
    addr_write();
    pulse_start();
    expect_state(1'b1, 1'b1, "R9 held over restart");
    send_byte(hdr(2'b10, 1'b0), 1'b1, "R9 header");
    send_byte(8'h11, 1'b1, "R9 data");
    expect_state(1'b1, 1'b1, "R9");
    pulse_stop();
  endtask

  task automatic t_rs_other();
    addr_write();
    pulse_start();
    send_byte(hdr(2'b11, 1'b0), 1'b0, "R10");
    expect_state(1'b0, 1'b0, "R10");
    send_byte(8'hB5, 1'b0, "R10 later");
    pulse_stop();
  endtask

  task automatic t_rs_read();
    addr_write();
    pulse_start();
    send_byte(hdr(2'b10, 1'b1), 1'b1, "R11 header");
    expect_state(1'b1, 1'b0, "R11");
    send_byte(8'h5A, 1'b0, "R11 data");
    pulse_stop();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic_write();
    t_hdr_miss();
    t_read_fresh();
    t_low_miss();
    t_rs_same();
    t_rs_other();
    t_rs_read();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule